// File: doc/BRIEF.md
# Optical Motion Sensor Register Model

This block stands in for the serial register interface of an optical motion sensor, so that a mouse-side controller under test can talk to it without real silicon. A host drives the four-wire serial bus in mode 3 (clock idles high, both sides capture on the rising clock edge and change data on the falling edge). The block decodes command bytes, serves a small register file with fixed power-on values, and streams a six-byte motion report from a dedicated burst address.

Motion is not sensed. A test harness injects signed X/Y displacements through a parallel port. The block accumulates them, raises an active-low motion flag, and hands them to the host through the status/delta register protocol. The serial inputs are oversampled by the system clock, so the serial clock must be several system clocks per half period. The firmware-load addresses accept bytes and discard them, and the firmware identity register reports a fixed value.

Top module: `motion_sensor_spi`

## Requirements
- R1: A transaction is the time `ncs` is low. Bytes are MSB first and sampled on rising `sclk`. In the first byte, bit 7 is 1 for a write and 0 for a read, and bits 6:0 hold the address. Read data leaves MSB first on `miso`, changing on falling edges, starting at the falling edge after the 8th rising edge. `miso` is 0 while `ncs` is high and throughout the command byte.
- R2: Transfers work with an `sclk` half period of 4 or more `clk` cycles.
- R3: Address 0x00 always reads 0x42, and writes to it have no effect.
- R4: After reset, the registers read as follows: 0x02 reads 0x20, 0x10 reads 0x20, 0x24 reads 0x00, 0x03–0x06 read 0x00, 0x25 and 0x26 read 0x00, and 0x2A reads 0x04. `motion_n` is high.
- R5: Address 0x10 (configuration) and address 0x24 (observation) read back the last value written to them.
- R6: An `inj_valid` cycle adds `inj_dx`/`inj_dy` (16-bit two's complement, wrapping) to the pending accumulators and marks motion pending. `motion_n` is low from the next cycle.
- R7: A read of 0x02 returns {pending, 0x20 low seven bits}, which is 0xA0 when pending. It copies the accumulators into the delta registers (0x03 X low, 0x04 X high, 0x05 Y low, 0x06 Y high) and zeroes the accumulators.
- R8: A read of a delta register returns its byte, then clears that byte and clears pending, so `motion_n` goes high.
- R9: Writing 0x5A to 0x3A restores every register, the accumulators, the pending flag and the burst arm to their reset state. Any other value written to 0x3A is ignored.
- R10: A write of any value to 0x50 arms the burst. A write to any other address disarms it. A read of 0x50 while armed streams six bytes in this order: status, observation, X low, X high, Y low, Y high. The burst latches the accumulators as in R7 and clears pending, and later bytes of the transaction read 0x00. A read of 0x50 while not armed returns 0x00.
- R11: Reads of unmapped addresses return 0x00. Writes to unmapped or read-only addresses are ignored. Bytes after the data byte of a write are ignored, and bytes after the first data byte of a non-burst read are 0x00.
- R12: Any write to 0x02 zeroes the accumulators and clears pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data from host |
| ncs | input | 1 | Active-low chip select |
| inj_valid | input | 1 | Injects one displacement sample |
| inj_dx | input | 16 | Signed X displacement |
| inj_dy | input | 16 | Signed Y displacement |
| miso | output | 1 | Serial data to host |
| motion_n | output | 1 | Active-low motion pending flag |

## Verification
The assertions assume that motion is injected only while `ncs` is high. They also assume that `sclk` and `mosi` change only at least two system clocks apart, so the synchronised edges are clean. The stimulus follows both rules: every injection happens between transactions, and every serial bit holds for several clock cycles. Under these rules, pending motion can be cleared only inside a transaction, and `miso` holds steady between falling edges.

// File: rtl/motion_sensor_spi.sv
module motion_sensor_spi #(
  parameter logic [7:0] PRODUCT_ID  = 8'h42,
  parameter logic [7:0] FW_ID       = 8'h04,
  parameter logic [7:0] STATUS_BASE = 8'h20,
  parameter logic [7:0] CFG_INIT    = 8'h20,
  parameter logic [7:0] RESET_KEY   = 8'h5A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        mosi,
  input  logic        ncs,
  input  logic        inj_valid,
  input  logic [15:0] inj_dx,
  input  logic [15:0] inj_dy,
  output logic        miso,
  output logic        motion_n
);
  localparam logic [6:0] A_PID   = 7'h00;
  localparam logic [6:0] A_STAT  = 7'h02;
  localparam logic [6:0] A_CFG   = 7'h10;
  localparam logic [6:0] A_OBS   = 7'h24;
  localparam logic [6:0] A_FWID  = 7'h2A;
  localparam logic [6:0] A_SRST  = 7'h3A;
  localparam logic [6:0] A_BURST = 7'h50;
  localparam int         BURST_LEN = 6;
  localparam int         BW = $clog2(BURST_LEN + 1);

  logic [SYNC_STAGES:0] sclk_p, mosi_p, ncs_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '1;
      ncs_p  <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk};
      ncs_p  <= {ncs_p[SYNC_STAGES-1:0], ncs};
      mosi_p <= {mosi_p[SYNC_STAGES-1:0], mosi};
    end

  wire sck_rise = sclk_p[SYNC_STAGES-1] & ~sclk_p[SYNC_STAGES];
  wire sck_fall = ~sclk_p[SYNC_STAGES-1] & sclk_p[SYNC_STAGES];
  wire cs_on    = ~ncs_p[SYNC_STAGES-1];
  wire cs_start = cs_on & ncs_p[SYNC_STAGES];
  wire mosi_s   = mosi_p[SYNC_STAGES-1];

  logic [2:0]    bit_cnt;
  logic [1:0]    byte_idx;
  logic [6:0]    sh_in;
  logic [7:0]    tx_sh;
  logic          miso_r;
  logic          is_wr;
  logic [6:0]    addr;
  logic          in_burst;
  logic [BW-1:0] bidx;

  logic [15:0] acc_x, acc_y;
  logic [7:0]  dreg [4];
  logic        pend, armed;
  logic [7:0]  cfg, obs;

  wire [7:0] rx_byte  = {sh_in, mosi_s};
  wire       byte_done = cs_on & ~cs_start & sck_rise & (bit_cnt == 3'd7);
  wire       cmd_done  = byte_done & (byte_idx == 2'd0);
  wire       cmd_rd    = cmd_done & ~rx_byte[7];
  wire [6:0] cmd_addr  = rx_byte[6:0];
  wire       wr_done   = byte_done & (byte_idx == 2'd1) & is_wr;
  wire       burst_go  = cmd_rd & (cmd_addr == A_BURST) & armed;
  wire       latch     = (cmd_rd & (cmd_addr == A_STAT)) | burst_go;
  wire       delta_rd  = cmd_rd & (cmd_addr >= 7'h03) & (cmd_addr <= 7'h06);
  wire [1:0] d_sel     = cmd_addr[1:0] + 2'd1;
  wire       soft_rst  = wr_done & (addr == A_SRST) & (rx_byte == RESET_KEY);
  wire       stat_clr  = wr_done & (addr == A_STAT);
  wire [7:0] status    = {pend, STATUS_BASE[6:0]};

  logic [7:0] rd_val, burst_val;
  always_comb begin
    case (cmd_addr)
      A_PID:   rd_val = PRODUCT_ID;
      A_STAT:  rd_val = status;
      7'h03:   rd_val = dreg[0];
      7'h04:   rd_val = dreg[1];
      7'h05:   rd_val = dreg[2];
      7'h06:   rd_val = dreg[3];
      A_CFG:   rd_val = cfg;
      A_OBS:   rd_val = obs;
      A_FWID:  rd_val = FW_ID;
      A_BURST: rd_val = armed ? status : 8'h00;
      default: rd_val = 8'h00;
    endcase
  end

  always_comb begin
    if (bidx == BW'(1))      burst_val = obs;
    else if (bidx >= BW'(2)) burst_val = dreg[2'(bidx - BW'(2))];
    else                     burst_val = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      sh_in    <= '0;
      tx_sh    <= '0;
      miso_r   <= 1'b0;
      is_wr    <= 1'b0;
      addr     <= '0;
      in_burst <= 1'b0;
      bidx     <= '0;
    end else if (!cs_on) begin
      miso_r   <= 1'b0;
    end else if (cs_start) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      tx_sh    <= '0;
      miso_r   <= 1'b0;
      in_burst <= 1'b0;
      bidx     <= '0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      sh_in   <= rx_byte[6:0];
      if (byte_done) begin
        if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
        if (cmd_done) begin
          is_wr    <= rx_byte[7];
          addr     <= cmd_addr;
          tx_sh    <= rx_byte[7] ? 8'h00 : rd_val;
          in_burst <= burst_go;
          bidx     <= BW'(1);
        end else if (in_burst && bidx < BW'(BURST_LEN)) begin
          tx_sh <= burst_val;
          bidx  <= bidx + BW'(1);
        end else begin
          tx_sh <= 8'h00;
        end
      end
    end else if (sck_fall) begin
      miso_r <= tx_sh[7];
      tx_sh  <= {tx_sh[6:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || soft_rst) begin
      acc_x <= '0;
      acc_y <= '0;
      for (int i = 0; i < 4; i++) dreg[i] <= '0;
      pend  <= 1'b0;
      armed <= 1'b0;
      cfg   <= CFG_INIT;
      obs   <= 8'h00;
    end else begin
      if (latch) begin
        dreg[0] <= acc_x[7:0];
        dreg[1] <= acc_x[15:8];
        dreg[2] <= acc_y[7:0];
        dreg[3] <= acc_y[15:8];
      end else if (delta_rd) begin
        dreg[d_sel] <= 8'h00;
      end
      if (latch || stat_clr) begin
        acc_x <= inj_valid ? inj_dx : 16'h0000;
        acc_y <= inj_valid ? inj_dy : 16'h0000;
      end else if (inj_valid) begin
        acc_x <= acc_x + inj_dx;
        acc_y <= acc_y + inj_dy;
      end
      if (inj_valid) pend <= 1'b1;
      else if (delta_rd || burst_go || stat_clr) pend <= 1'b0;
      if (wr_done) begin
        armed <= (addr == A_BURST);
        if (addr == A_CFG) cfg <= rx_byte;
        if (addr == A_OBS) obs <= rx_byte;
      end
    end

  assign miso     = ~ncs & miso_r;
  assign motion_n = ~pend;
endmodule

module motion_sensor_spi_chk (
  input logic clk,
  input logic rst_n,
  input logic ncs,
  input logic miso,
  input logic motion_n,
  input logic inj_valid,
  input logic cs_on,
  input logic sck_fall,
  input logic miso_r
);
  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ncs |-> !miso);
  // R1
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on && $past(cs_on) && !$past(sck_fall)) |-> $stable(miso_r));
  // R6
  motion_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && ncs) |=> !motion_n);
  // R6
  motion_only_inj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (motion_n && !inj_valid) |=> motion_n);
  // R8
  motion_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motion_n) |-> $past(cs_on));
endmodule

bind motion_sensor_spi motion_sensor_spi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ncs(ncs), .miso(miso), .motion_n(motion_n),
  .inj_valid(inj_valid), .cs_on(cs_on), .sck_fall(sck_fall), .miso_r(miso_r)
);

// File: tb/motion_sensor_spi_bench.sv
module motion_sensor_spi_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, mosi = 1'b0, ncs = 1'b1;
  logic inj_valid = 1'b0;
  logic [15:0] inj_dx = '0, inj_dy = '0;
  logic miso, motion_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  motion_sensor_spi u_motion_sensor_spi (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ncs(ncs),
    .inj_valid(inj_valid), .inj_dx(inj_dx), .inj_dy(inj_dy),
    .miso(miso), .motion_n(motion_n)
  );

  int checks = 0, failures = 0, blank = 8, half = 6;
  bit done = 0, watch_on = 0;

  logic [15:0] m_ax, m_ay;
  logic [7:0]  m_d [4];
  logic [7:0]  m_cfg, m_obs;
  bit          m_pend, m_arm;
  logic [7:0]  txq [8];
  logic [7:0]  rxq [8];
  logic [7:0]  expq [8];

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_ax = '0; m_ay = '0;
    for (int i = 0; i < 4; i++) m_d[i] = '0;
    m_cfg = 8'h20; m_obs = 8'h00; m_pend = 0; m_arm = 0;
  endfunction

  function automatic void model_latch();
    m_d[0] = m_ax[7:0]; m_d[1] = m_ax[15:8];
    m_d[2] = m_ay[7:0]; m_d[3] = m_ay[15:8];
    m_ax = '0; m_ay = '0;
  endfunction

  function automatic void model_read(input logic [6:0] a);
    for (int i = 0; i < 8; i++) expq[i] = 8'h00;
    case (a)
      7'h00: expq[1] = 8'h42;
      7'h02: begin expq[1] = {m_pend, 7'h20}; model_latch(); end
      7'h03, 7'h04, 7'h05, 7'h06: begin
        expq[1] = m_d[a - 7'h03]; m_d[a - 7'h03] = 8'h00; m_pend = 0;
      end
      7'h10: expq[1] = m_cfg;
      7'h24: expq[1] = m_obs;
      7'h2A: expq[1] = 8'h04;
      7'h50: if (m_arm) begin
        expq[1] = {m_pend, 7'h20};
        model_latch();
        m_pend = 0;
        expq[2] = m_obs;
        for (int i = 0; i < 4; i++) expq[3 + i] = m_d[i];
      end
      default: ;
    endcase
  endfunction

  function automatic void model_write(input logic [6:0] a, input logic [7:0] d);
    m_arm = (a == 7'h50);
    case (a)
      7'h3A: if (d == 8'h5A) model_reset();
      7'h10: m_cfg = d;
      7'h24: m_obs = d;
      7'h02: begin m_ax = '0; m_ay = '0; m_pend = 0; end
      default: ;
    endcase
  endfunction

  task automatic spi_txn(input int n, input string req);
    ncs = 1'b0;
    repeat (half) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      logic [7:0] r;
      r = '0;
      for (int i = 7; i >= 0; i--) begin
        sclk = 1'b0; mosi = txq[b][i];
        repeat (half) @(negedge clk);
        r[i] = miso;
        blank = 3 * half;
        sclk = 1'b1;
        repeat (half) @(negedge clk);
      end
      rxq[b] = r;
      if (b == 0 && !txq[0][7]) model_read(txq[0][6:0]);
      if (b == 1 && txq[0][7]) model_write(txq[0][6:0], txq[1]);
    end
    ncs = 1'b1;
    repeat (3 * half) @(negedge clk);
    chk(rxq[0], 8'h00, "R1 miso quiet during command");
    if (!txq[0][7])
      for (int b = 1; b < n; b++) chk(rxq[b], expq[b], req);
  endtask

  task automatic rd(input logic [6:0] a, input int n, input string req);
    txq[0] = {1'b0, a};
    for (int i = 1; i < 8; i++) txq[i] = 8'h00;
    spi_txn(n, req);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input string req);
    txq[0] = {1'b1, a}; txq[1] = d;
    spi_txn(2, req);
  endtask

  task automatic inject(input logic [15:0] dx, input logic [15:0] dy);
    @(negedge clk);
    blank = 4;
    inj_valid = 1'b1; inj_dx = dx; inj_dy = dy;
    @(negedge clk);
    inj_valid = 1'b0;
    m_ax = m_ax + dx; m_ay = m_ay + dy; m_pend = 1;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (watch_on && !done) begin
      if (blank > 0) blank--;
      else chk({7'b0, motion_n}, {7'b0, ~m_pend}, "R6/R8 motion_n per cycle");
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({7'b0, motion_n}, 8'h01, "R4 motion_n after reset");
    chk({7'b0, miso}, 8'h00, "R1 miso idle");
    watch_on = 1;

    half = 4;
    rd(7'h00, 2, "R2 R3 product id at fastest clock");
    half = 6;
    wr(7'h00, 8'h11, "R3 write ignored");
    rd(7'h00, 2, "R3 product id");

    rd(7'h02, 2, "R4 status default");
    rd(7'h10, 2, "R4 config default");
    rd(7'h24, 2, "R4 observation default");
    for (int a = 3; a <= 6; a++) rd(7'(a), 2, "R4 delta default");
    rd(7'h25, 2, "R4 data out low");
    rd(7'h26, 2, "R4 data out high");
    rd(7'h2A, 2, "R4 firmware id");

    wr(7'h10, 8'h00, "R5");
    rd(7'h10, 2, "R5 config readback");
    wr(7'h24, 8'h5C, "R5");
    rd(7'h24, 2, "R5 observation readback");

    wr(7'h11, 8'h55, "R11");
    rd(7'h11, 2, "R11 unmapped read");
    rd(7'h7F, 2, "R11 unmapped read");
    txq[0] = 8'h90; txq[1] = 8'h33; txq[2] = 8'h77;
    spi_txn(3, "R11 extra write byte");
    rd(7'h10, 3, "R11 extra read byte zero");
    wr(7'h25, 8'hAA, "R11");
    rd(7'h25, 2, "R11 read-only unchanged");

    inject(16'h0003, 16'hFFFE);
    chk({7'b0, motion_n}, 8'h00, "R6 motion asserted");
    inject(16'h0100, 16'h0005);
    rd(7'h02, 2, "R7 status pending");
    chk({7'b0, motion_n}, 8'h00, "R7 motion held after status read");
    for (int a = 3; a <= 6; a++) rd(7'(a), 2, "R8 delta value");
    chk({7'b0, motion_n}, 8'h01, "R8 motion released");
    rd(7'h03, 2, "R8 delta cleared");
    rd(7'h02, 2, "R7 status idle");

    wr(7'h10, 8'h33, "R5");
    wr(7'h3A, 8'h00, "R9");
    rd(7'h10, 2, "R9 wrong key ignored");
    inject(16'h0042, 16'h0001);
    wr(7'h3A, 8'h5A, "R9");
    rd(7'h10, 2, "R9 config restored");
    rd(7'h24, 2, "R9 observation restored");
    rd(7'h02, 2, "R9 status restored");
    chk({7'b0, motion_n}, 8'h01, "R9 motion cleared");

    rd(7'h50, 7, "R10 unarmed burst");
    wr(7'h24, 8'h9D, "R5");
    wr(7'h50, 8'h00, "R10 arm");
    inject(16'hFFFF, 16'h1234);
    rd(7'h50, 8, "R10 burst stream");
    chk({7'b0, motion_n}, 8'h01, "R10 burst clears motion");
    wr(7'h10, 8'h20, "R10 disarm");
    inject(16'h0007, 16'h0000);
    rd(7'h50, 3, "R10 disarmed burst");

    wr(7'h02, 8'h00, "R12");
    chk({7'b0, motion_n}, 8'h01, "R12 motion cleared by status write");
    rd(7'h02, 2, "R12 status after clear");
    rd(7'h03, 2, "R12 accumulator zeroed");

    repeat (20) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule